// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Splitter

This block sits right after instruction memory in a small 32-bit processor. Memory returns a six-byte window that starts at the current program counter. The block splits that window into the fields of one instruction: the opcode and function nibbles, the two register specifiers, and a 32-bit constant. It also produces the address of the following instruction. Instructions are 1, 2, 5 or 6 bytes long depending on the opcode, so the opcode decides both where the constant sits and how far the program counter advances.

The block is purely combinational and holds no state, so every output follows the current window and program counter within the same cycle. Two flags tell the downstream decoder whether a register byte and a constant were present. A third flag marks an opcode outside the defined set. Window byte k is carried on `bytes_i[8k+7:8k]`, so byte 0, the opcode byte, sits in bits 7:0.

Top module: `insn_fetch_split`

## Requirements
- R1: `icode_o` equals bits 7:4 of window byte 0 and `ifun_o` equals bits 3:0 of window byte 0, for every opcode.
- R2: For opcodes 2, 3, 4, 5, 6, 0xA and 0xB, `ra_o` equals bits 7:4 of byte 1 and `rb_o` equals bits 3:0 of byte 1, passed through unchanged.
- R3: For opcodes 0, 1, 7, 8, 9 and any opcode above 0xB, `ra_o` and `rb_o` both read 4'h8, which means no register.
- R4: For opcodes 3, 4 and 5, `valc_o` is bytes 2 to 5 taken little-endian, with byte 2 as the least significant byte.
- R5: For opcodes 7 and 8, `valc_o` is bytes 1 to 4 taken little-endian, with byte 1 as the least significant byte, and byte 5 has no effect on it.
- R6: For every opcode that carries no constant (0, 1, 2, 6, 9, 0xA, 0xB and above 0xB), `valc_o` is zero.
- R7: `valp_o` equals `pc_i` plus the instruction length, wrapping modulo 2^32. The length is 1 for opcodes 0, 1 and 9, 2 for 2, 6, 0xA and 0xB, 5 for 7 and 8, 6 for 3, 4 and 5, and 1 for any opcode above 0xB.
- R8: `bad_op_o` is high exactly when the opcode nibble is above 0xB.
- R9: `need_reg_o` is high exactly for the opcodes listed in R2, and `need_const_o` is high exactly for the opcodes listed in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of window byte 0 |
| bytes_i | input | 48 | Six fetched bytes; byte k in bits 8k+7:8k |
| icode_o | output | 4 | Opcode nibble |
| ifun_o | output | 4 | Function nibble |
| ra_o | output | 4 | First register specifier, 4'h8 when absent |
| rb_o | output | 4 | Second register specifier, 4'h8 when absent |
| valc_o | output | 32 | Assembled constant, zero when absent |
| valp_o | output | 32 | Address of the next sequential instruction |
| need_reg_o | output | 1 | Instruction carries a register byte |
| need_const_o | output | 1 | Instruction carries a 32-bit constant |
| bad_op_o | output | 1 | Opcode is undefined |

## Verification
No register lies between any input and any output, so every result is due in the same cycle as the stimulus that produces it, after zero clock edges. The bench changes the program counter and the window on the falling clock edge. It samples all outputs 2 ns later, before the next rising edge, so each check sees values that have settled from exactly one stimulus. The check that byte 5 is ignored for jumps changes only that byte between two samples and compares the constant at the same settled point.

// File: rtl/fsplit_pkg.sv
package fsplit_pkg;

  localparam int NIB_W     = 4;
  localparam int BYTE_W    = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W    = WORD_BYTES * BYTE_W;
  localparam int WIN_BYTES = 6;
  localparam int WIN_W     = WIN_BYTES * BYTE_W;
  localparam int LEN_W     = 3;

  localparam logic [NIB_W-1:0] NO_REG = 4'h8;

  typedef enum logic [NIB_W-1:0] {
    OP_NOP    = 4'h0,
    OP_HALT   = 4'h1,
    OP_RRMOV  = 4'h2,
    OP_IRMOV  = 4'h3,
    OP_RMMOV  = 4'h4,
    OP_MRMOV  = 4'h5,
    OP_ALU    = 4'h6,
    OP_JUMP   = 4'h7,
    OP_CALL   = 4'h8,
    OP_RET    = 4'h9,
    OP_PUSH   = 4'hA,
    OP_POP    = 4'hB
  } opcode_e;

  localparam logic [NIB_W-1:0] OP_LAST = OP_POP;

  function automatic logic op_defined(input logic [NIB_W-1:0] op);
    return op <= OP_LAST;
  endfunction

  function automatic logic op_has_reg(input logic [NIB_W-1:0] op);
    logic r;
    case (op)
      OP_RRMOV, OP_IRMOV, OP_RMMOV, OP_MRMOV,
      OP_ALU, OP_PUSH, OP_POP: r = 1'b1;
      default:                 r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic op_has_const(input logic [NIB_W-1:0] op);
    logic r;
    case (op)
      OP_IRMOV, OP_RMMOV, OP_MRMOV, OP_JUMP, OP_CALL: r = 1'b1;
      default:                                        r = 1'b0;
    endcase
    return r;
  endfunction

  // Length is built from its parts: one opcode byte, an optional register
  // byte, an optional four-byte constant.
  function automatic logic [LEN_W-1:0] op_length(input logic [NIB_W-1:0] op);
    logic [LEN_W-1:0] n;
    n = LEN_W'(1);
    if (op_has_reg(op))   n = n + LEN_W'(1);
    if (op_has_const(op)) n = n + LEN_W'(WORD_BYTES);
    return n;
  endfunction

endpackage

// File: rtl/fsplit_classify.sv
module fsplit_classify
  import fsplit_pkg::*;
(
  input  logic [NIB_W-1:0] op_i,
  output logic             defined_o,
  output logic             has_reg_o,
  output logic             has_const_o,
  output logic             const_late_o,
  output logic [LEN_W-1:0] len_o
);

  always_comb begin
    defined_o    = op_defined(op_i);
    has_reg_o    = op_has_reg(op_i);
    has_const_o  = op_has_const(op_i);
    // Constant begins at byte 2 when a register byte precedes it.
    const_late_o = has_reg_o && has_const_o;
    len_o        = op_length(op_i);
  end

endmodule

// File: rtl/fsplit_const_pick.sv
module fsplit_const_pick
  import fsplit_pkg::*;
(
  input  logic [(WIN_BYTES-1)*BYTE_W-1:0] tail_i,
  input  logic                            late_i,
  input  logic                            enable_i,
  output logic [WORD_W-1:0]               word_o
);

  // tail_i holds window bytes 1..5; tail byte j is window byte j+1.
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    logic [BYTE_W-1:0] early_b;
    logic [BYTE_W-1:0] late_b;
    assign early_b = tail_i[k*BYTE_W +: BYTE_W];
    assign late_b  = tail_i[(k+1)*BYTE_W +: BYTE_W];
    assign word_o[k*BYTE_W +: BYTE_W] =
      enable_i ? (late_i ? late_b : early_b) : '0;
  end

endmodule

// File: rtl/fsplit_next_pc.sv
module fsplit_next_pc
  import fsplit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] next_o
);

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a,
                                             input logic [LEN_W-1:0]  n);
    return a + {{(ADDR_W-LEN_W){1'b0}}, n};
  endfunction

  assign next_o = step(pc_i, len_i);

endmodule

// File: rtl/insn_fetch_split.sv
module insn_fetch_split
  import fsplit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [WIN_W-1:0]  bytes_i,
  output logic [NIB_W-1:0]  icode_o,
  output logic [NIB_W-1:0]  ifun_o,
  output logic [NIB_W-1:0]  ra_o,
  output logic [NIB_W-1:0]  rb_o,
  output logic [WORD_W-1:0] valc_o,
  output logic [ADDR_W-1:0] valp_o,
  output logic              need_reg_o,
  output logic              need_const_o,
  output logic              bad_op_o
);

  logic [BYTE_W-1:0]                 head_b;
  logic [BYTE_W-1:0]                 reg_b;
  logic [(WIN_BYTES-1)*BYTE_W-1:0]   tail_w;
  logic                              op_ok_w;
  logic                              has_reg_w;
  logic                              has_const_w;
  logic                              const_late_w;
  logic [LEN_W-1:0]                  len_w;

  assign head_b = bytes_i[BYTE_W-1:0];
  assign tail_w = bytes_i[WIN_W-1:BYTE_W];
  assign reg_b  = tail_w[BYTE_W-1:0];

  assign icode_o = head_b[BYTE_W-1:NIB_W];
  assign ifun_o  = head_b[NIB_W-1:0];

  fsplit_classify u_cls (
    .op_i        (icode_o),
    .defined_o   (op_ok_w),
    .has_reg_o   (has_reg_w),
    .has_const_o (has_const_w),
    .const_late_o(const_late_w),
    .len_o       (len_w)
  );

  assign ra_o = has_reg_w ? reg_b[BYTE_W-1:NIB_W] : NO_REG;
  assign rb_o = has_reg_w ? reg_b[NIB_W-1:0]      : NO_REG;

  fsplit_const_pick u_cst (
    .tail_i  (tail_w),
    .late_i  (const_late_w),
    .enable_i(has_const_w),
    .word_o  (valc_o)
  );

  fsplit_next_pc #(.ADDR_W(ADDR_W)) u_npc (
    .pc_i  (pc_i),
    .len_i (len_w),
    .next_o(valp_o)
  );

  assign need_reg_o   = has_reg_w;
  assign need_const_o = has_const_w;
  assign bad_op_o     = !op_ok_w;

endmodule

// File: rtl/insn_fetch_split_chk.sv
module insn_fetch_split_chk
  import fsplit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic [ADDR_W-1:0] pc_i,
  input logic [WIN_W-1:0]  bytes_i,
  input logic [NIB_W-1:0]  ra_o,
  input logic [NIB_W-1:0]  rb_o,
  input logic [WORD_W-1:0] valc_o,
  input logic [ADDR_W-1:0] valp_o,
  input logic              need_reg_o,
  input logic              need_const_o,
  input logic              bad_op_o,
  input logic [LEN_W-1:0]  len_w
);

  logic [ADDR_W-1:0] span;

  always_comb begin
    span = valp_o - pc_i;

    // R3: absent register byte shows as no-register in both fields
    assert_noreg_R3: assert (need_reg_o || (ra_o == NO_REG && rb_o == NO_REG))
      else $error("R3 register fields not forced");

    // R6: absent constant reads zero
    assert_const_zero_R6: assert (need_const_o || valc_o == '0)
      else $error("R6 constant not zero");

    // R4: six-byte form takes its constant from bytes 2..5
    assert_const_late_R4: assert (!(need_const_o && need_reg_o) ||
                                  valc_o == bytes_i[WIN_W-1:2*BYTE_W])
      else $error("R4 constant misplaced");

    // R7: the advance matches the classifier length and is a legal size
    assert_len_R7: assert (span == ADDR_W'(len_w) &&
                           (span == 1 || span == 2 || span == 5 || span == 6))
      else $error("R7 bad advance");

    // R8: an undefined opcode carries nothing and advances one byte
    assert_bad_R8: assert (!bad_op_o || (!need_reg_o && !need_const_o && span == 1))
      else $error("R8 bad opcode not isolated");

    // R9: flags agree with the advance
    assert_flags_R9: assert ((span == 6) == (need_reg_o && need_const_o) &&
                             (span == 5) == (!need_reg_o && need_const_o))
      else $error("R9 flags disagree with length");
  end

endmodule

bind insn_fetch_split insn_fetch_split_chk #(.ADDR_W(ADDR_W)) u_chk (
  .pc_i        (pc_i),
  .bytes_i     (bytes_i),
  .ra_o        (ra_o),
  .rb_o        (rb_o),
  .valc_o      (valc_o),
  .valp_o      (valp_o),
  .need_reg_o  (need_reg_o),
  .need_const_o(need_const_o),
  .bad_op_o    (bad_op_o),
  .len_w       (len_w)
);

// File: tb/insn_fetch_split_test.sv
module insn_fetch_split_test;

  logic        clk = 1'b0;
  logic [31:0] pc  = '0;
  logic [47:0] win = '0;
  logic [3:0]  icode, ifun, ra, rb;
  logic [31:0] valc, valp;
  logic        nreg, ncst, bad;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  insn_fetch_split uut (
    .pc_i(pc), .bytes_i(win), .icode_o(icode), .ifun_o(ifun),
    .ra_o(ra), .rb_o(rb), .valc_o(valc), .valp_o(valp),
    .need_reg_o(nreg), .need_const_o(ncst), .bad_op_o(bad)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [47:0] win;   // written byte5 .. byte0
    logic [31:0] valc;
    logic [31:0] valp;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic        bad;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0100, 48'hFFFFFFFFFF00, 32'h0,         32'h0000_0101, 4'h8, 4'h8, 1'b0},
    '{32'h0000_0200, 48'h123456789A10, 32'h0,         32'h0000_0201, 4'h8, 4'h8, 1'b0},
    '{32'h0000_0300, 48'hAAAAAAAA3420, 32'h0,         32'h0000_0302, 4'h3, 4'h4, 1'b0},
    '{32'h0000_0400, 48'h123456788230, 32'h1234_5678, 32'h0000_0406, 4'h8, 4'h2, 1'b0},
    '{32'h0000_1000, 48'h000000FC1540, 32'h0000_00FC, 32'h0000_1006, 4'h1, 4'h5, 1'b0},
    '{32'h0000_0000, 48'hDEADBEEF7350, 32'hDEAD_BEEF, 32'h0000_0006, 4'h7, 4'h3, 1'b0},
    '{32'h0000_0500, 48'h555555552661, 32'h0,         32'h0000_0502, 4'h2, 4'h6, 1'b0},
    '{32'h0000_0600, 48'h990000064071, 32'h0000_0640, 32'h0000_0605, 4'h8, 4'h8, 1'b0},
    '{32'hFFFF_FFFC, 48'h771122334480, 32'h1122_3344, 32'h0000_0001, 4'h8, 4'h8, 1'b0},
    '{32'h0000_0700, 48'h000000000090, 32'h0,         32'h0000_0701, 4'h8, 4'h8, 1'b0},
    '{32'h0000_0800, 48'h0000000048A0, 32'h0,         32'h0000_0802, 4'h4, 4'h8, 1'b0},
    '{32'h0000_0900, 48'h0000000008B0, 32'h0,         32'h0000_0902, 4'h0, 4'h8, 1'b0},
    '{32'h0000_1234, 48'h1234567812C5, 32'h0,         32'h0000_1235, 4'h8, 4'h8, 1'b1},
    '{32'hFFFF_FFFF, 48'hFFFFFFFFFFFF, 32'h0,         32'h0000_0000, 4'h8, 4'h8, 1'b1},
    '{32'hFFFF_FFFE, 48'h80000001F730, 32'h8000_0001, 32'h0000_0004, 4'hF, 4'h7, 1'b0},
    '{32'h0000_0020, 48'h00FFFFFFFF70, 32'hFFFF_FFFF, 32'h0000_0025, 4'h8, 4'h8, 1'b0}
  };

  // Bench's own view of the instruction set: opcode -> length in bytes.
  function automatic int blen(input logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'h9:       return 1;
      4'h2, 4'h6, 4'hA, 4'hB: return 2;
      4'h7, 4'h8:             return 5;
      4'h3, 4'h4, 4'h5:       return 6;
      default:                return 1;
    endcase
  endfunction

  function automatic bit bregs(input logic [3:0] op);
    return (op <= 4'hB) && (blen(op) == 2 || blen(op) == 6);
  endfunction

  function automatic bit bconst(input logic [3:0] op);
    return (op <= 4'hB) && (blen(op) >= 5);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [47:0] act,
                     input logic [47:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (pc=%h win=%h)", tag, act, exp, pc, win);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [47:0] w);
    @(negedge clk);
    pc  = p;
    win = w;
    #2;
  endtask

  initial begin
    // Idle state: all-zero window decodes as a one-byte no-op.
    #2;
    chk(icode == 4'h0 && ifun == 4'h0, "R1", {40'h0, icode, ifun}, 48'h0);
    chk(valp == 32'h1, "R7", {16'h0, valp}, 48'h1);
    chk(ra == 4'h8 && rb == 4'h8, "R3", {40'h0, ra, rb}, 48'h88);
    chk(valc == 32'h0 && !bad, "R6", {15'h0, bad, valc}, 48'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].pc, VECS[i].win);
      chk(icode == VECS[i].win[7:4] && ifun == VECS[i].win[3:0], "R1",
          {40'h0, icode, ifun}, {40'h0, VECS[i].win[7:0]});
      chk(ra == VECS[i].ra && rb == VECS[i].rb,
          bregs(VECS[i].win[7:4]) ? "R2" : "R3",
          {40'h0, ra, rb}, {40'h0, VECS[i].ra, VECS[i].rb});
      chk(valc == VECS[i].valc,
          !bconst(VECS[i].win[7:4]) ? "R6" : (bregs(VECS[i].win[7:4]) ? "R4" : "R5"),
          {16'h0, valc}, {16'h0, VECS[i].valc});
      chk(valp == VECS[i].valp, "R7", {16'h0, valp}, {16'h0, VECS[i].valp});
      chk(bad == VECS[i].bad, "R8", {47'h0, bad}, {47'h0, VECS[i].bad});
    end

    // Opcode sweep: flags, length and undefined marker for all 16 codes.
    for (int op = 0; op < 16; op++) begin
      apply(32'h0001_0000, {40'h3C5A_9617_E2, 4'(op), 4'h0});
      chk(nreg == bregs(4'(op)), "R9", {47'h0, nreg}, {47'h0, bregs(4'(op))});
      chk(ncst == bconst(4'(op)), "R9", {47'h0, ncst}, {47'h0, bconst(4'(op))});
      chk(valp == 32'h0001_0000 + 32'(blen(4'(op))), "R7", {16'h0, valp},
          {16'h0, 32'h0001_0000 + 32'(blen(4'(op)))});
      chk(bad == (op > 11), "R8", {47'h0, bad}, {47'h0, op > 11});
    end

    // Byte 5 is ignored by a call: change only that byte.
    apply(32'h40, 48'h00CAFEF00D80);
    chk(valc == 32'hCAFE_F00D, "R5", {16'h0, valc}, 48'hCAFEF00D);
    apply(32'h40, 48'hFFCAFEF00D80);
    chk(valc == 32'hCAFE_F00D, "R5", {16'h0, valc}, 48'hCAFEF00D);

    // Register byte ignored by a jump even when it looks like registers.
    apply(32'h80, 48'h000000001273);
    chk(ra == 4'h8 && rb == 4'h8, "R3", {40'h0, ra, rb}, 48'h88);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule